// File: doc/BRIEF.md
# Packet-Committing Endpoint FIFO Writer

This block is the device-side write port of a synchronous slave FIFO that feeds IN endpoints. An external master drives a write strobe, a data word, an endpoint address and a packet-end strobe, all sampled on one interface clock. For each endpoint the block counts the words of the packet now being assembled. It also keeps a running modulo-2^W sum of that packet's data.

A packet closes in one of two ways. It closes automatically when its word count reaches a programmable auto-length. It closes early when the master samples packet-end, which commits a short packet. Each closed packet becomes a descriptor that holds its length, its endpoint and its data sum. Descriptors queue in a small FIFO and leave through a valid/ready handshake. Registered full and empty flags go back to the master.

There is one timing hazard. Suppose an automatic commit is followed on the very next edge by a one-word packet closed with packet-end. That one-word packet is lost. The block drops it and raises a sticky error flag.

Top module: `ep_fifo_writer`

## Requirements
- R1: When a write takes an endpoint's pending count to the auto-length, a descriptor with length equal to the auto-length is committed on that edge. The written word is the last word of that packet, and the endpoint's count restarts at zero.
- R2: A sampled packet-end commits the pending words of the endpoint on `wrAddr` as a short packet, including any word written on the same edge. If packet-end falls on the same edge as an automatic commit for that endpoint, it is absorbed and only the automatic packet is produced.
- R3: A packet-end with zero pending words, and no hazard, commits a zero-length descriptor with sum 0.
- R4: A packet-end on the edge right after an automatic commit of the same endpoint, which would close a one-word packet, commits nothing. It clears that endpoint's count and sets `hazardErr`, which stays high until reset.
- R5: Each endpoint (index 0 to NUM_EP-1 on `wrAddr`) keeps its own count and sum. Writes to one endpoint never advance another.
- R6: A descriptor carries `descLen` (word count), `descEp` (endpoint) and `descSum` (sum of the packet's data words modulo 2^W).
- R7: Descriptors leave in commit order. Each is held stable with `descValid` high until a cycle with `descReady` high.
- R8: `fullFlag` is a registered flag that is high exactly when DEPTH descriptors are queued. While it is high, writes and packet-end are ignored.
- R9: `emptyFlag` is a registered flag that is high exactly when no descriptor is queued and no endpoint has pending words.
- R10: The auto-length resets to DEF_LEN. A `cfgWe` write of `cfgLen` takes effect only if no endpoint has pending words before that edge and 1 <= `cfgLen` <= LEN_MAX; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | EPW | Endpoint selected for write and packet-end |
| wrData | input | W | Write data word |
| pktEnd | input | 1 | Packet-end strobe |
| cfgWe | input | 1 | Auto-length write enable |
| cfgLen | input | CW | New auto-length value |
| descValid | output | 1 | Descriptor available |
| descReady | input | 1 | Consumer accepts descriptor |
| descLen | output | CW | Committed packet length |
| descEp | output | EPW | Committed packet endpoint |
| descSum | output | W | Sum of the committed packet's data |
| fullFlag | output | 1 | Descriptor queue full; master must hold off |
| emptyFlag | output | 1 | Nothing queued or pending |
| hazardErr | output | 1 | Sticky flag for a dropped one-word packet |

## Verification
The automatic commit and the packet-end commit can fall on the same edge for the same endpoint. The bench provokes this by writing the final word of an auto-length packet together with packet-end, and expects exactly one full-length descriptor with nothing behind it. The two also collide one edge apart. The bench sends a write plus packet-end right after an auto commit and expects the one-word packet to vanish and the error flag to latch. It then repeats the sequence with one idle edge before packet-end and expects the one-word descriptor to appear. A behavioural model compares every output on every cycle.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  // Strobes from control to datapath for the endpoint on epSel
  typedef struct packed {
    logic accEn;   // add wrData to the endpoint's running sum
    logic commit;  // push a descriptor
    logic clear;   // restart the endpoint's sum
  } fwrStrobe_t;
endpackage

// File: rtl/fwr_ctrl.sv
module fwr_ctrl
  import fwr_pkg::*;
#(
  parameter int NUM_EP  = 2,
  parameter int LEN_MAX = 15,
  parameter int DEF_LEN = 4,
  parameter int EPW     = 1,
  parameter int CW      = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [EPW-1:0] wrAddr,
  input  logic           pktEnd,
  input  logic           cfgWe,
  input  logic [CW-1:0]  cfgLen,
  input  logic           fullFlag,
  output fwrStrobe_t     strobe,
  output logic [CW-1:0]  commitLen,
  output logic           pendNext,
  output logic           hazardErr
);
  localparam logic [EPW:0] EP_LIM = (EPW+1)'(NUM_EP);

  logic [NUM_EP-1:0][CW-1:0] cnt, cntNext;
  logic [NUM_EP-1:0]         prevAuto, autoNext;
  logic [CW-1:0]             autoLen;
  logic                      errQ;
  logic                      epHit, writeOk, endOk, autoHit, hazard, cfgOk;
  logic [CW-1:0]             curCnt, newCnt;
  logic                      curPrev;

  assign epHit   = {1'b0, wrAddr} < EP_LIM;
  assign writeOk = wrEn && !fullFlag && epHit;
  assign endOk   = pktEnd && !fullFlag && epHit;

  always_comb begin
    curCnt  = '0;
    curPrev = 1'b0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (wrAddr == EPW'(e)) begin
        curCnt  = cnt[e];
        curPrev = prevAuto[e];
      end
    end
  end

  assign newCnt  = curCnt + CW'(writeOk);
  assign autoHit = writeOk && (newCnt == autoLen);
  assign hazard  = endOk && !autoHit && curPrev && (newCnt == CW'(1));

  always_comb begin
    strobe.accEn  = writeOk;
    strobe.commit = autoHit || (endOk && !hazard);
    strobe.clear  = autoHit || endOk;
    commitLen     = autoHit ? autoLen : newCnt;
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : gEp
    logic selE;
    assign selE        = epHit && (wrAddr == EPW'(e));
    assign cntNext[e]  = selE ? (strobe.clear ? '0 : newCnt) : cnt[e];
    assign autoNext[e] = selE && autoHit;
  end

  assign pendNext = |cntNext;
  assign cfgOk    = cfgWe && !(|cnt) && (cfgLen != '0) && (cfgLen <= CW'(LEN_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      prevAuto <= '0;
      autoLen  <= CW'(DEF_LEN);
      errQ     <= 1'b0;
    end else begin
      cnt      <= cntNext;
      prevAuto <= autoNext;
      errQ     <= errQ | hazard;
      if (cfgOk) autoLen <= cfgLen;
    end
  end

  assign hazardErr = errQ;

  // A commit without packet-end can only be an automatic one
  assert_auto_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !pktEnd) |-> (commitLen == autoLen));
  // Once set, the loss flag holds
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    hazardErr |=> hazardErr);
  // Auto-length frozen while any packet is in progress
  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|cnt) |=> $stable(autoLen));
  assert_len_min_R10: assert property (@(posedge clk) disable iff (!rstN)
    autoLen != '0);
endmodule

// File: rtl/fwr_datapath.sv
module fwr_datapath
  import fwr_pkg::*;
#(
  parameter int NUM_EP = 2,
  parameter int W      = 8,
  parameter int DEPTH  = 4,
  parameter int EPW    = 1,
  parameter int CW     = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  fwrStrobe_t     strobe,
  input  logic [EPW-1:0] epSel,
  input  logic [CW-1:0]  commitLen,
  input  logic [W-1:0]   wrData,
  input  logic           pendNext,
  input  logic           descReady,
  output logic           descValid,
  output logic [CW-1:0]  descLen,
  output logic [EPW-1:0] descEp,
  output logic [W-1:0]   descSum,
  output logic           fullFlag,
  output logic           emptyFlag
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [NUM_EP-1:0][W-1:0] acc;
  logic [W-1:0]             curAcc, pktSum;

  always_comb begin
    curAcc = '0;
    for (int e = 0; e < NUM_EP; e++)
      if (epSel == EPW'(e)) curAcc = acc[e];
  end
  assign pktSum = curAcc + (strobe.accEn ? wrData : '0);

  for (genvar e = 0; e < NUM_EP; e++) begin : gAcc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) acc[e] <= '0;
      else if (epSel == EPW'(e)) begin
        if (strobe.clear)      acc[e] <= '0;
        else if (strobe.accEn) acc[e] <= pktSum;
      end
    end
  end

  // Descriptor queue
  logic [CW-1:0]  memLen [DEPTH];
  logic [EPW-1:0] memEp  [DEPTH];
  logic [W-1:0]   memSum [DEPTH];
  logic [PW-1:0]  wrPtr, rdPtr;
  logic [OW-1:0]  occ, occNext;
  logic           push, pop;

  assign push      = strobe.commit;
  assign descValid = occ != '0;
  assign pop       = descValid && descReady;
  assign occNext   = occ + OW'(push) - OW'(pop);

  always_ff @(posedge clk) begin
    if (push) begin
      memLen[wrPtr] <= commitLen;
      memEp[wrPtr]  <= epSel;
      memSum[wrPtr] <= pktSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occ       <= '0;
      fullFlag  <= 1'b0;
      emptyFlag <= 1'b1;
    end else begin
      if (push) wrPtr <= (wrPtr == PW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      occ       <= occNext;
      fullFlag  <= occNext == OW'(DEPTH);
      emptyFlag <= (occNext == '0) && !pendNext;
    end
  end

  assign descLen = memLen[rdPtr];
  assign descEp  = memEp[rdPtr];
  assign descSum = memSum[rdPtr];

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !strobe.commit);
  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OW'(DEPTH));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(descLen) && $stable(descEp) && $stable(descSum)));
endmodule

// File: rtl/ep_fifo_writer.sv
module ep_fifo_writer
  import fwr_pkg::*;
#(
  parameter int NUM_EP  = 2,
  parameter int W       = 8,
  parameter int DEPTH   = 4,
  parameter int LEN_MAX = 15,
  parameter int DEF_LEN = 4,
  localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int CW     = $clog2(LEN_MAX + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [EPW-1:0] wrAddr,
  input  logic [W-1:0]   wrData,
  input  logic           pktEnd,
  input  logic           cfgWe,
  input  logic [CW-1:0]  cfgLen,
  output logic           descValid,
  input  logic           descReady,
  output logic [CW-1:0]  descLen,
  output logic [EPW-1:0] descEp,
  output logic [W-1:0]   descSum,
  output logic           fullFlag,
  output logic           emptyFlag,
  output logic           hazardErr
);
  fwrStrobe_t    strobe;
  logic [CW-1:0] commitLen;
  logic          pendNext;

  fwr_ctrl #(.NUM_EP(NUM_EP), .LEN_MAX(LEN_MAX), .DEF_LEN(DEF_LEN), .EPW(EPW), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .pktEnd(pktEnd),
    .cfgWe(cfgWe), .cfgLen(cfgLen), .fullFlag(fullFlag), .strobe(strobe),
    .commitLen(commitLen), .pendNext(pendNext), .hazardErr(hazardErr)
  );

  fwr_datapath #(.NUM_EP(NUM_EP), .W(W), .DEPTH(DEPTH), .EPW(EPW), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .epSel(wrAddr), .commitLen(commitLen),
    .wrData(wrData), .pendNext(pendNext), .descReady(descReady), .descValid(descValid),
    .descLen(descLen), .descEp(descEp), .descSum(descSum), .fullFlag(fullFlag),
    .emptyFlag(emptyFlag)
  );
endmodule

// File: tb/tb_ep_fifo_writer.sv
`timescale 1ns/1ps
module tb_ep_fifo_writer;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, pktEnd = 0, cfgWe = 0, descReady = 1;
  logic [0:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] cfgLen = '0;
  logic descValid, fullFlag, emptyFlag, hazardErr;
  logic [3:0] descLen;
  logic [0:0] descEp;
  logic [7:0] descSum;

  ep_fifo_writer dut (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { int len; int ep; int sum; } desc_t;
  desc_t mq[$];
  int mCnt[2], mSum[2], mLen;
  bit mPrev[2], mFull, mErr, mEmpty;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mq.delete(); mCnt = '{0,0}; mSum = '{0,0}; mPrev = '{0,0};
      mLen = 4; mFull = 0; mErr = 0; mEmpty = 1;
    end else begin
      bit doPush, doPop, anyPend;
      bit newPrev[2];
      desc_t item;
      newPrev = '{0,0};
      doPush = 0;
      doPop = (mq.size() > 0) && descReady;
      anyPend = (mCnt[0] != 0) || (mCnt[1] != 0);
      if (!mFull) begin
        int e, nc, ns;
        e  = int'(wrAddr);
        nc = mCnt[e] + (wrEn ? 1 : 0);
        ns = (mSum[e] + (wrEn ? int'(wrData) : 0)) & 255;
        if (wrEn && nc == mLen) begin
          item = '{mLen, e, ns}; doPush = 1; mCnt[e] = 0; mSum[e] = 0; newPrev[e] = 1;
        end else if (pktEnd) begin
          if (mPrev[e] && nc == 1) mErr = 1;
          else begin item = '{nc, e, ns}; doPush = 1; end
          mCnt[e] = 0; mSum[e] = 0;
        end else begin
          mCnt[e] = nc; mSum[e] = ns;
        end
      end
      mPrev = newPrev;
      if (cfgWe && !anyPend && cfgLen >= 1 && cfgLen <= 15) mLen = int'(cfgLen);
      if (doPop) void'(mq.pop_front());
      if (doPush) mq.push_back(item);
      mFull  = mq.size() == DEPTH;
      mEmpty = (mq.size() == 0) && mCnt[0] == 0 && mCnt[1] == 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic compareAll();
    chk(descValid == (mq.size() > 0), "R7 descValid", descValid, mq.size() > 0);
    if (descValid && mq.size() > 0) begin
      chk(int'(descLen) == mq[0].len, "R6 descLen", descLen, mq[0].len);
      chk(int'(descEp)  == mq[0].ep,  "R6 descEp",  descEp,  mq[0].ep);
      chk(int'(descSum) == mq[0].sum, "R6 descSum", descSum, mq[0].sum);
    end
    chk(fullFlag == mFull,   "R8 fullFlag",  fullFlag,  mFull);
    chk(emptyFlag == mEmpty, "R9 emptyFlag", emptyFlag, mEmpty);
    chk(hazardErr == mErr,   "R4 hazardErr", hazardErr, mErr);
  endtask

  // ---------------- accepted-descriptor log ----------------
  int recLen[$], recEp[$], recSum[$];

  task automatic tick();
    if (descValid && descReady) begin
      recLen.push_back(descLen); recEp.push_back(descEp); recSum.push_back(descSum);
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
    wrEn = 0; pktEnd = 0; cfgWe = 0;
  endtask

  task automatic wr(input int ep, input int d, input bit pe = 0);
    wrEn = 1; wrAddr = ep[0:0]; wrData = d[7:0]; pktEnd = pe; tick();
  endtask
  task automatic endOnly(input int ep);
    pktEnd = 1; wrAddr = ep[0:0]; tick();
  endtask
  task automatic cfg(input int v);
    cfgWe = 1; cfgLen = v[3:0]; tick();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expectPop(input string tag, input int len, input int ep, input int sum);
    if (recLen.size() == 0) begin
      chk(0, {tag, " missing descriptor"}, 0, 1);
    end else begin
      int l, e, s;
      l = recLen.pop_front(); e = recEp.pop_front(); s = recSum.pop_front();
      chk(l == len, {tag, " len"}, l, len);
      chk(e == ep,  {tag, " ep"},  e, ep);
      chk(s == sum, {tag, " sum"}, s, sum);
    end
  endtask
  task automatic expectNone(input string tag);
    chk(recLen.size() == 0, {tag, " extra descriptor"}, recLen.size(), 0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 20000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", nFails, nChecks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(descValid == 0, "R7 reset descValid", descValid, 0);
    chk(fullFlag == 0, "R8 reset fullFlag", fullFlag, 0);
    chk(emptyFlag == 1, "R9 reset emptyFlag", emptyFlag, 1);
    chk(hazardErr == 0, "R4 reset hazardErr", hazardErr, 0);

    // R1: automatic commit at default length 4
    wr(0, 10); wr(0, 20); wr(0, 30); wr(0, 40); idle(2);
    expectPop("R1 auto", 4, 0, 100);

    // R2: short packet, packet-end with last write
    wr(1, 1); wr(1, 2); wr(1, 3, 1); idle(2);
    expectPop("R2 short", 3, 1, 6);

    // R3: zero-length packet
    endOnly(0); idle(2);
    expectPop("R3 zero", 0, 0, 0);

    // R4: hazard, one-word packet right after auto commit is dropped
    wr(0, 5); wr(0, 5); wr(0, 5); wr(0, 5); wr(0, 7, 1); idle(2);
    expectPop("R4 auto before drop", 4, 0, 20);
    expectNone("R4 dropped");
    chk(hazardErr == 1, "R4 sticky set", hazardErr, 1);
    endOnly(0); idle(2);
    expectPop("R4 count cleared", 0, 0, 0);

    // R4: compliant spacing, one-word packet survives
    wr(1, 1); wr(1, 1); wr(1, 1); wr(1, 1); wr(1, 9); endOnly(1); idle(2);
    expectPop("R4 compliant auto", 4, 1, 4);
    expectPop("R4 compliant one-word", 1, 1, 9);

    // R2: packet-end on the auto-commit edge is absorbed
    wr(0, 1); wr(0, 1); wr(0, 1); wr(0, 2, 1); idle(3);
    expectPop("R2 absorbed", 4, 0, 5);
    expectNone("R2 absorbed");

    // R5: interleaved endpoints
    wr(0, 1); wr(1, 5); wr(0, 2); wr(1, 6); wr(0, 3); wr(1, 7); wr(0, 4);
    endOnly(1); idle(2);
    expectPop("R5 ep0", 4, 0, 10);
    expectPop("R5 ep1", 3, 1, 18);

    // R8: fill queue, writes and packet-end ignored while full
    descReady = 0;
    endOnly(0); endOnly(0); endOnly(0); endOnly(0);
    chk(fullFlag == 1, "R8 full set", fullFlag, 1);
    wr(1, 50); endOnly(1);
    descReady = 1; idle(6);
    for (int i = 0; i < 4; i++) expectPop("R8 queued", 0, 0, 0);
    expectNone("R8 ignored endOnly");
    endOnly(1); idle(2);
    expectPop("R8 ignored write", 0, 1, 0);

    // R10: config gated by pending words and range
    wr(0, 1); cfg(2); wr(0, 1); wr(0, 1); wr(0, 1); idle(2);
    expectPop("R10 rejected busy", 4, 0, 4);
    cfg(0); wr(0, 2); wr(0, 2); wr(0, 2); wr(0, 2); idle(2);
    expectPop("R10 rejected zero", 4, 0, 8);
    cfg(2); wr(0, 3); wr(0, 4); idle(2);
    expectPop("R10 accepted", 2, 0, 7);
    cfg(4); idle(2);
    chk(emptyFlag == 1, "R9 idle empty", emptyFlag, 1);

    $display("Result: errors=%0d of %0d checks", nFails, nChecks);
    $finish;
  end
endmodule